// File: doc/BRIEF.md
# Bit-Error Tester Status and Sticky Interrupt Registers

This block keeps the status and interrupt state for one channel of a bit-error-rate tester. It receives four level conditions from the rest of the channel: loss of pattern lock, a nonzero accumulated error count, completion of a counter snapshot, and an external snapshot-request pin. It also receives a one-cycle strobe for each detected bit error. All of these are synchronized to the register clock. Software can read them through a live status register, and each one also sets a bit in a sticky register that software clears by writing ones.

The snapshot-done flag counts only while the selected snapshot request is high. A mode input selects either a software request bit or the external pin as that request. When the request drops, the flag in the live register falls in the same cycle, without waiting for the synchronizers. Each sticky bit is ANDed with its own enable, and the interrupt output is the registered OR of those terms, qualified by a port-level enable and a global enable. Both registers are placed in a per-channel address window set by a parameter.

Top module: `ber_status_regs`

## Requirements
- R1: The live status register is at address CHAN_IDX*0x80 + 0x5C. Bit 0 is loss-of-lock, bit 1 is error-count-nonzero and bit 3 is snapshot-done. All other bits read 0.
- R2: After a synchronous reset the live register reads 0x0001, because loss-of-lock resets to 1. The sticky register reads 0 and `irq_out` is 0.
- R3: Bit 3 of the live register equals the synchronized done input ANDed with the active request. The active request is `sw_upd_req` when `upd_src_sel`=0 and `upd_req_pin` when `upd_src_sel`=1. When the active request goes low, bit 3 reads 0 in the same cycle.
- R4: The sticky register is at CHAN_IDX*0x80 + 0x5E and uses bit positions 0, 1 and 3 as in R1, with bit 2 for bit errors. Writes to the live register have no effect, and any other address reads 0.
- R5: Sticky bit 0 sets on any change of the synchronized loss-of-lock flag, rising or falling.
- R6: Sticky bits 1 and 3 set only when their live flags go from 0 to 1. A falling flag leaves them clear.
- R7: Sticky bit 2 sets on every clock in which the synchronized bit-error strobe is high.
- R8: Writing a 1 to a sticky bit clears it, and writing a 0 leaves it unchanged. If a set event and a clear fall in the same cycle, the bit ends up set.
- R9: `irq_out` is 1 one cycle after all of the following hold: `glob_irq_en`=1, `port_irq_en`=1, and some sticky bit is set while `bit_irq_en` has a 1 in the same position.
- R10: An input change reaches the live register after 2 clock edges and a sticky bit after 3 clock edges, and `irq_out` follows after 4 clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| oos_in | input | 1 | Pattern checker not locked |
| errcnt_nz_in | input | 1 | Accumulated error count is nonzero |
| snap_done_in | input | 1 | All requested counter snapshots completed |
| bit_err_evt | input | 1 | One-cycle strobe per detected bit error |
| upd_req_pin | input | 1 | External snapshot request |
| sw_upd_req | input | 1 | Software snapshot request |
| upd_src_sel | input | 1 | 0 selects the software request, 1 selects the pin |
| bit_irq_en | input | 4 | Per-bit interrupt enables, same positions as the sticky register |
| port_irq_en | input | 1 | Port-level status interrupt enable |
| glob_irq_en | input | 1 | Global per-port interrupt enable |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the same cycle as the access |
| irq_out | output | 1 | Registered interrupt request |

## Verification
A level input change made between clock edges appears in the live register after two edges, in the sticky register after three, and on the interrupt after four. A change on the request select or the request inputs clears the done bit immediately. The bench drives inputs at falling edges and reads at falling edges that are exactly that many edges later. In several checks it also reads one edge early, to show that the result is not yet visible. The interrupt enables are applied directly to the interrupt register, so each enable change is checked one edge later. The clear-versus-set collision is checked by placing the write on the same edge as the third edge after the strobe.

// File: rtl/ber_stat_pkg.sv
// Package: shared constants and latch-rule selection for the status block.
// Assumes 16-bit registers and four status flag positions.
package ber_stat_pkg;
    localparam int REG_W     = 16;
    localparam int NUM_FLAGS = 4;
    localparam int B_OOS     = 0;
    localparam int B_NZ      = 1;
    localparam int B_ERR     = 2;
    localparam int B_PM      = 3;
    localparam int CH_STRIDE = 'h80;
    localparam int OFF_LIVE  = 'h5C;
    localparam int OFF_STICK = 'h5E;

    typedef enum logic [1:0] {LR_RISE, LR_ANY, LR_EVENT} latch_rule_e;

    // Selects the sticky set rule for a flag position.
    function automatic latch_rule_e rule_of(input int b);
        case (b)
            B_OOS:   return LR_ANY;
            B_ERR:   return LR_EVENT;
            default: return LR_RISE;
        endcase
    endfunction
endpackage

// File: rtl/ber_sync.sv
// Module: multi-stage synchronizer bank for W independent single-bit inputs.
// Assumes each input is either a level or a pulse at least one clock wide.
module ber_sync #(
    parameter int           W       = 4,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage samples the raw inputs.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= RST_VAL;
                else        stg[s] <= d;
            end
        end else begin : g_next
            // Later stages resample the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= RST_VAL;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/ber_sticky.sv
// Module: sticky status bits with a per-position set rule (rise, any edge,
// or raw event), write-one-to-clear, and set taking priority over clear.
// Assumes live inputs are already synchronous to clk.
module ber_sticky
    import ber_stat_pkg::*;
#(
    parameter int           NF       = NUM_FLAGS,
    parameter logic [NF-1:0] PREV_RST = NF'(1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] live,
    input  logic [NF-1:0] clr,
    output logic [NF-1:0] lat_q
);
    logic [NF-1:0] prev_q;
    logic [NF-1:0] set_v;

    for (genvar b = 0; b < NF; b++) begin : g_rule
        if (rule_of(b) == LR_ANY) begin : g_any
            assign set_v[b] = live[b] ^ prev_q[b];
        end else if (rule_of(b) == LR_EVENT) begin : g_evt
            assign set_v[b] = live[b];
        end else begin : g_rise
            assign set_v[b] = live[b] & ~prev_q[b];
        end
    end

    // Remember last live values for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= PREV_RST;
        else        prev_q <= live;
    end

    // Sticky update: clear by write, then set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= (lat_q & ~clr) | set_v;
    end

    // R5
    oos_any_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lat_q[B_OOS]) |-> ($past(live[B_OOS]) != $past(live[B_OOS], 2)));

    // R6
    nz_rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lat_q[B_NZ]) |-> ($past(live[B_NZ]) && !$past(live[B_NZ], 2)));

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((lat_q & $past(set_v)) == $past(set_v)));

    // R8
    fall_needs_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((($past(lat_q) & ~lat_q) & ~$past(clr)) == '0));
endmodule

// File: rtl/ber_irq_gate.sv
// Module: three-level interrupt enable chain with a registered output.
// Assumes enables are synchronous to clk.
module ber_irq_gate #(
    parameter int NF = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] lat,
    input  logic [NF-1:0] bit_en,
    input  logic          port_en,
    input  logic          glob_en,
    output logic          irq_q
);
    // Register the qualified OR of enabled sticky bits.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= glob_en & port_en & (|(lat & bit_en));
    end

    // R9
    irq_needs_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> ($past(glob_en) && $past(port_en)));

    // R9
    irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(glob_en && port_en && (|(lat & bit_en)))) |-> irq_q);
endmodule

// File: rtl/ber_status_regs.sv
// Module: top of the bit-error tester status block. Synchronizes live
// conditions, exposes live and sticky registers at a per-channel address,
// and raises a gated interrupt.
// Assumes single-cycle register accesses with combinational read data.
module ber_status_regs
    import ber_stat_pkg::*;
#(
    parameter int CHAN_IDX    = 0,
    parameter int ADDR_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              oos_in,
    input  logic              errcnt_nz_in,
    input  logic              snap_done_in,
    input  logic              bit_err_evt,
    input  logic              upd_req_pin,
    input  logic              sw_upd_req,
    input  logic              upd_src_sel,
    input  logic [3:0]        bit_irq_en,
    input  logic              port_irq_en,
    input  logic              glob_irq_en,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              irq_out
);
    localparam int                BASE       = CHAN_IDX * CH_STRIDE;
    localparam logic [ADDR_W-1:0] LIVE_ADDR  = ADDR_W'(BASE + OFF_LIVE);
    localparam logic [ADDR_W-1:0] STICK_ADDR = ADDR_W'(BASE + OFF_STICK);
    localparam int                NIN        = 5;

    logic [NIN-1:0]       raw_in, syn;
    logic                 oos_s, nz_s, err_s, done_s, pin_s;
    logic                 req_now, req_syn;
    logic [NUM_FLAGS-1:0] live_v, clr_v, lat_v;
    logic [REG_W-1:0]     live_word;

    assign raw_in = {upd_req_pin, snap_done_in, bit_err_evt, errcnt_nz_in, oos_in};

    ber_sync #(.W(NIN), .STAGES(SYNC_STAGES), .RST_VAL(NIN'(1))) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn)
    );

    assign {pin_s, done_s, err_s, nz_s, oos_s} = syn;

    // Request as seen by the live register (raw, so a drop forces low at once).
    assign req_now = upd_src_sel ? upd_req_pin : sw_upd_req;
    // Request as seen by the edge detector (synchronized path).
    assign req_syn = upd_src_sel ? pin_s : sw_upd_req;

    always_comb begin
        live_v        = '0;
        live_v[B_OOS] = oos_s;
        live_v[B_NZ]  = nz_s;
        live_v[B_ERR] = err_s;
        live_v[B_PM]  = done_s & req_syn;
    end

    // Live register image; bit 2 and upper bits read zero.
    always_comb begin
        live_word        = '0;
        live_word[B_OOS] = oos_s;
        live_word[B_NZ]  = nz_s;
        live_word[B_PM]  = done_s & req_now;
    end

    // Write-one-to-clear strobe for the sticky register only.
    assign clr_v = (bus_sel && bus_wr && bus_addr == STICK_ADDR)
                   ? bus_wdata[NUM_FLAGS-1:0] : '0;

    ber_sticky #(.NF(NUM_FLAGS), .PREV_RST(NUM_FLAGS'(1))) u_sticky (
        .clk(clk), .rst_n(rst_n), .live(live_v), .clr(clr_v), .lat_q(lat_v)
    );

    ber_irq_gate #(.NF(NUM_FLAGS)) u_irq (
        .clk(clk), .rst_n(rst_n), .lat(lat_v), .bit_en(bit_irq_en),
        .port_en(port_irq_en), .glob_en(glob_irq_en), .irq_q(irq_out)
    );

    // Read mux: live or sticky image, zero elsewhere.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (bus_addr == LIVE_ADDR)       bus_rdata = live_word;
            else if (bus_addr == STICK_ADDR) bus_rdata = REG_W'(lat_v);
        end
    end

    // R2
    reset_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (lat_v == '0 && !irq_out));

    // R3
    done_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == LIVE_ADDR && !req_now) |-> !bus_rdata[B_PM]);
endmodule

// File: tb/sim_ber_status_regs.sv
`timescale 1ns/1ps
module sim_ber_status_regs;
    localparam int CH = 1;
    localparam logic [15:0] A_LIVE  = 16'(CH * 'h80 + 'h5C);
    localparam logic [15:0] A_STICK = 16'(CH * 'h80 + 'h5E);

    // Row: {oos, nz, done, src_sel, sw_req, pin, expected live[3:0]}
    localparam logic [9:0] VEC [0:7] = '{
        {6'b000000, 4'h0},
        {6'b100000, 4'h1},
        {6'b010000, 4'h2},
        {6'b001010, 4'h8},
        {6'b001001, 4'h0},
        {6'b001101, 4'h8},
        {6'b001110, 4'h0},
        {6'b111101, 4'hB}
    };

    logic clk = 0, rst_n = 0;
    logic oos_in = 0, errcnt_nz_in = 0, snap_done_in = 0, bit_err_evt = 0;
    logic upd_req_pin = 0, sw_upd_req = 0, upd_src_sel = 0;
    logic [3:0] bit_irq_en = 0;
    logic port_irq_en = 0, glob_irq_en = 0;
    logic bus_sel = 0, bus_wr = 0;
    logic [15:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
    logic irq_out;
    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ber_status_regs #(.CHAN_IDX(CH)) u0 (
        .clk(clk), .rst_n(rst_n), .oos_in(oos_in), .errcnt_nz_in(errcnt_nz_in),
        .snap_done_in(snap_done_in), .bit_err_evt(bit_err_evt),
        .upd_req_pin(upd_req_pin), .sw_upd_req(sw_upd_req), .upd_src_sel(upd_src_sel),
        .bit_irq_en(bit_irq_en), .port_irq_en(port_irq_en), .glob_irq_en(glob_irq_en),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [15:0] a, output logic [15:0] d);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] v);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        wt(3);
        rst_n = 1;
        // R2: state right after reset, before any further edge
        rd(A_LIVE, d);  chk("R2 live", d, 16'h0001);
        rd(A_STICK, d); chk("R2 sticky", d, 16'h0000);
        chk("R2 irq", {15'b0, irq_out}, 16'h0000);
        @(negedge clk);

        // Table walk: R1 layout and R3 request selection
        for (int i = 0; i < 8; i++) begin
            {oos_in, errcnt_nz_in, snap_done_in, upd_src_sel, sw_upd_req, upd_req_pin} = VEC[i][9:4];
            wt(3);
            rd(A_LIVE, d);
            chk("R1/R3 table", d, {12'b0, VEC[i][3:0]});
            @(negedge clk);
        end

        // Return to idle, clear all sticky bits
        {oos_in, errcnt_nz_in, snap_done_in, upd_src_sel, sw_upd_req, upd_req_pin} = '0;
        wt(4);
        wr(A_STICK, 16'h000F);
        rd(A_STICK, d); chk("R8 clear all", d, 16'h0000);
        @(negedge clk);

        // R6: count-nonzero rising sets, falling does not
        errcnt_nz_in = 1; wt(3);
        rd(A_STICK, d); chk("R6 nz rise", d, 16'h0002);
        @(negedge clk); wr(A_STICK, 16'h000F);
        errcnt_nz_in = 0; wt(3);
        rd(A_STICK, d); chk("R6 nz fall", d, 16'h0000);
        @(negedge clk);

        // R5/R10: loss-of-lock either edge, live after 2 edges
        oos_in = 1; wt(1);
        rd(A_LIVE, d); chk("R10 live early", d, 16'h0000);
        @(negedge clk);
        rd(A_LIVE, d); chk("R10 live due", d, 16'h0001);
        @(negedge clk);
        rd(A_STICK, d); chk("R5 oos rise", d, 16'h0001);
        @(negedge clk); wr(A_STICK, 16'h000F);
        oos_in = 0; wt(3);
        rd(A_STICK, d); chk("R5 oos fall", d, 16'h0001);
        @(negedge clk); wr(A_STICK, 16'h000F);

        // R3/R6: snapshot-done through the software request
        sw_upd_req = 1; snap_done_in = 1; wt(3);
        rd(A_STICK, d); chk("R6 done rise", d, 16'h0008);
        rd(A_LIVE, d);  chk("R3 done live", d, 16'h0008);
        sw_upd_req = 0;
        rd(A_LIVE, d);  chk("R3 sw force low", d, 16'h0000);
        @(negedge clk); wr(A_STICK, 16'h000F);
        wt(2);
        rd(A_STICK, d); chk("R6 done fall", d, 16'h0000);
        @(negedge clk);
        sw_upd_req = 1; wt(3);
        rd(A_STICK, d); chk("R6 done rise again", d, 16'h0008);
        // pin source
        upd_src_sel = 1; sw_upd_req = 0; upd_req_pin = 1; wt(3);
        rd(A_LIVE, d);  chk("R3 pin source", d, 16'h0008);
        upd_req_pin = 0;
        rd(A_LIVE, d);  chk("R3 pin force low", d, 16'h0000);
        @(negedge clk);
        snap_done_in = 0; upd_src_sel = 0; wt(3);
        wr(A_STICK, 16'h000F);

        // R7/R10: single error strobe
        bit_err_evt = 1; @(negedge clk); bit_err_evt = 0; @(negedge clk);
        rd(A_STICK, d); chk("R10 sticky early", d, 16'h0000);
        @(negedge clk);
        rd(A_STICK, d); chk("R7 error strobe", d, 16'h0004);
        @(negedge clk);

        // R8: partial clear keeps other bits
        errcnt_nz_in = 1; wt(3);
        wr(A_STICK, 16'h0004);
        rd(A_STICK, d); chk("R8 partial clear", d, 16'h0002);
        @(negedge clk);
        errcnt_nz_in = 0; wt(3);
        wr(A_STICK, 16'h000F);

        // R8: set and clear on the same edge, set wins
        bit_err_evt = 1; @(negedge clk); bit_err_evt = 0; @(negedge clk);
        wr(A_STICK, 16'h0004);
        rd(A_STICK, d); chk("R8 set wins", d, 16'h0004);
        @(negedge clk);

        // R4: live register write ignored, foreign addresses read zero
        wr(A_LIVE, 16'hFFFF);
        rd(A_STICK, d); chk("R4 live write ignored", d, 16'h0004);
        rd(A_LIVE, d);  chk("R4 live unchanged", d, 16'h0000);
        rd(A_LIVE + 16'h0080, d); chk("R4 other channel", d, 16'h0000);
        rd(16'h005C, d); chk("R4 channel 0 address", d, 16'h0000);
        @(negedge clk);

        // R9: enable chain, sticky holds bit 2
        bit_irq_en = 4'h4; port_irq_en = 1; glob_irq_en = 0; @(negedge clk);
        chk("R9 global off", {15'b0, irq_out}, 16'h0000);
        glob_irq_en = 1; @(negedge clk);
        chk("R9 all on", {15'b0, irq_out}, 16'h0001);
        port_irq_en = 0; @(negedge clk);
        chk("R9 port off", {15'b0, irq_out}, 16'h0000);
        port_irq_en = 1; bit_irq_en = 4'h8; @(negedge clk);
        chk("R9 bit enable mismatch", {15'b0, irq_out}, 16'h0000);
        bit_irq_en = 4'hF; @(negedge clk);
        chk("R9 bit enable match", {15'b0, irq_out}, 16'h0001);
        wr(A_STICK, 16'h000F); @(negedge clk);
        chk("R9 cleared drops irq", {15'b0, irq_out}, 16'h0000);

        // R10: interrupt four edges after the strobe
        bit_err_evt = 1; @(negedge clk); bit_err_evt = 0; wt(2);
        chk("R10 irq early", {15'b0, irq_out}, 16'h0000);
        @(negedge clk);
        chk("R10 irq due", {15'b0, irq_out}, 16'h0001);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule